// File: doc/BRIEF.md
# Branch-Over-One Predication Fuser

This block sits in the decode stage of a two-lane issue pipeline. In each cycle it looks at the pair of decoded instructions about to issue. Lane A holds the older instruction and lane B the younger. The block fuses the pair when both of these hold:

- the lane A instruction is a conditional branch whose forward target lands just past the lane B instruction;
- the lane B instruction is a single-cycle ALU operation.

A fused pair issues together and no prediction is made for the branch. In the execute cycle, the comparison flags from the lane A comparator decide whether lane B may write its result. A taken branch turns the lane B instruction into a no-op by dropping its writeback enable.

Pairs that are not fused pass through unchanged: lane B writes back exactly as it was decoded to. The comparator and the register file lie outside the block. The block sees only the comparator's equal, signed-less-than and unsigned-less-than flags, and it evaluates the branch condition from them.

Control is a three-state machine that tracks the pair now in execute.

- `ST_IDLE`: no pair is in execute.
- `ST_PASS`: an unfused pair is in execute.
- `ST_FUSED`: a fused pair is in execute.

At every clock edge the next state is chosen from the decode-stage inputs. A cycle without a valid pair goes to `ST_IDLE`. A valid pair that meets every fusion rule goes to `ST_FUSED`. Any other valid pair goes to `ST_PASS`. Reset forces `ST_IDLE`.

Top module: `branch_skip_fuse`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `fuse_o` and `b_wb_en_o` are both 0.
- R2: A valid pair is fused, and `fuse_o` is 1 in the cycle after the pair is presented, when all of these hold:
  - the lane A kind is branch (code 3) with a known condition;
  - the lane B kind is ALU (code 0);
  - `b_pc_i` equals `a_pc_i` plus the lane A length;
  - `a_pc_i + a_offs_i` equals `b_pc_i` plus the lane B length.
- R3: Lengths are 2 bytes when the matching `*_short_i` is 1 and 4 bytes otherwise. The target check uses the real length of each of the two instructions, for all four size combinations.
- R4: A pair with any other branch offset is never fused. This includes a zero, backward, too-short or too-long offset.
- R5: A lane B kind other than ALU is never fused: load 1, store 2, branch 3, multi-cycle 4, or the reserved codes 5 to 7.
- R6: A lane A kind other than branch is never fused. A branch with an unknown condition code (2 or 3) is never fused either.
- R7: A pair whose lane B PC does not follow lane A directly is never fused.
- R8: For a fused pair in execute, `b_wb_en_o` equals the decoded lane B write flag AND NOT the branch outcome. If lane B does not write, the enable stays 0 whatever the flags are.
- R9: The branch outcome is computed from the flags presented in the execute cycle, using these condition codes:

  | Code | Branch taken when |
  |------|-------------------|
  | 0 | equal flag is 1 |
  | 1 | equal flag is 0 |
  | 4 | signed-less-than flag is 1 |
  | 5 | signed-less-than flag is 0 |
  | 6 | unsigned-less-than flag is 1 |
  | 7 | unsigned-less-than flag is 0 |
- R10: For an unfused valid pair in execute, `fuse_o` is 0 and `b_wb_en_o` equals the decoded lane B write flag, regardless of the comparison flags.
- R11: In the cycle after a cycle without a valid pair, `fuse_o` and `b_wb_en_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| pair_vld_i | input | 1 | A decoded pair is present this cycle |
| a_pc_i | input | XLEN | Lane A instruction address |
| a_short_i | input | 1 | Lane A is a 16-bit instruction |
| a_kind_i | input | 3 | Lane A kind code |
| a_cond_i | input | 3 | Lane A branch condition code |
| a_offs_i | input | XLEN | Lane A signed branch offset |
| b_pc_i | input | XLEN | Lane B instruction address |
| b_short_i | input | 1 | Lane B is a 16-bit instruction |
| b_kind_i | input | 3 | Lane B kind code |
| b_wr_i | input | 1 | Lane B writes a destination register |
| flag_eq_i | input | 1 | Execute-cycle comparator: operands equal |
| flag_lt_i | input | 1 | Execute-cycle comparator: signed less-than |
| flag_ltu_i | input | 1 | Execute-cycle comparator: unsigned less-than |
| fuse_o | output | 1 | The pair now in execute is fused |
| b_wb_en_o | output | 1 | Lane B writeback enable for the pair in execute |

## Verification
The hardest situation to reach is a fused pair whose branch resolves taken. The decode-time fields and the execute-time flags belong to different cycles, so the stimulus must line them up across the clock edge. Each scenario first presents a pair that meets every fusion rule. On the following half cycle it withdraws the pair and drives one of the eight flag combinations. It then samples the writeback enable before the next edge, so every condition code is seen both taken and not taken.

Near-miss pairs are also built on purpose:
- the offset is off by one halfword;
- a 16-bit lane B is checked as if it were 32-bit;
- lane B is not adjacent to lane A.

For each of these, the flags are set so that a wrongly fused pair would drop the writeback.

// File: rtl/bsf_pkg.sv
package bsf_pkg;

    typedef enum logic [2:0] {
        K_ALU    = 3'd0,
        K_LOAD   = 3'd1,
        K_STORE  = 3'd2,
        K_BRANCH = 3'd3,
        K_MULDIV = 3'd4
    } kind_e;

    typedef enum logic [2:0] {
        C_EQ  = 3'd0,
        C_NE  = 3'd1,
        C_LT  = 3'd4,
        C_GE  = 3'd5,
        C_LTU = 3'd6,
        C_GEU = 3'd7
    } cond_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PASS  = 2'd1,
        ST_FUSED = 2'd2
    } fsm_e;

    localparam int unsigned SHORT_BYTES = 2;
    localparam int unsigned LONG_BYTES  = 4;

    function automatic logic cond_known(input logic [2:0] c);
        return (c != 3'd2) && (c != 3'd3);
    endfunction

endpackage

// File: rtl/bsf_detect.sv
module bsf_detect
    import bsf_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic            vld_i,
    input  logic [XLEN-1:0] a_pc_i,
    input  logic            a_short_i,
    input  logic [2:0]      a_kind_i,
    input  logic [2:0]      a_cond_i,
    input  logic [XLEN-1:0] a_offs_i,
    input  logic [XLEN-1:0] b_pc_i,
    input  logic            b_short_i,
    input  logic [2:0]      b_kind_i,
    output logic            fuse_o
);
    localparam logic [XLEN-1:0] LEN_S = XLEN'(SHORT_BYTES);
    localparam logic [XLEN-1:0] LEN_L = XLEN'(LONG_BYTES);

    logic [XLEN-1:0] len_a, len_b, target, past_b;
    logic            adjacent, forward, lands, kinds_ok;

    always_comb begin
        len_a    = a_short_i ? LEN_S : LEN_L;
        len_b    = b_short_i ? LEN_S : LEN_L;
        target   = a_pc_i + a_offs_i;
        past_b   = b_pc_i + len_b;
        adjacent = (b_pc_i == a_pc_i + len_a);
        forward  = ($signed(a_offs_i) > 0);
        lands    = (target == past_b);
        kinds_ok = (a_kind_i == K_BRANCH) && cond_known(a_cond_i)
                && (b_kind_i == K_ALU);
        fuse_o   = vld_i && kinds_ok && adjacent && forward && lands;
    end

endmodule

// File: rtl/bsf_cond.sv
module bsf_cond
    import bsf_pkg::*;
(
    input  logic [2:0] cond_i,
    input  logic       eq_i,
    input  logic       lt_i,
    input  logic       ltu_i,
    output logic       taken_o
);
    always_comb begin
        unique case (cond_i)
            C_EQ:    taken_o = eq_i;
            C_NE:    taken_o = !eq_i;
            C_LT:    taken_o = lt_i;
            C_GE:    taken_o = !lt_i;
            C_LTU:   taken_o = ltu_i;
            C_GEU:   taken_o = !ltu_i;
            default: taken_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/branch_skip_fuse.sv
module branch_skip_fuse
    import bsf_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            pair_vld_i,
    input  logic [XLEN-1:0] a_pc_i,
    input  logic            a_short_i,
    input  logic [2:0]      a_kind_i,
    input  logic [2:0]      a_cond_i,
    input  logic [XLEN-1:0] a_offs_i,
    input  logic [XLEN-1:0] b_pc_i,
    input  logic            b_short_i,
    input  logic [2:0]      b_kind_i,
    input  logic            b_wr_i,
    input  logic            flag_eq_i,
    input  logic            flag_lt_i,
    input  logic            flag_ltu_i,
    output logic            fuse_o,
    output logic            b_wb_en_o
);
    fsm_e       state_q, state_d;
    logic [2:0] cond_q;
    logic       bwr_q;
    logic       fuse_dec;
    logic       taken;

    bsf_detect #(.XLEN(XLEN)) u_detect (
        .vld_i     (pair_vld_i),
        .a_pc_i    (a_pc_i),
        .a_short_i (a_short_i),
        .a_kind_i  (a_kind_i),
        .a_cond_i  (a_cond_i),
        .a_offs_i  (a_offs_i),
        .b_pc_i    (b_pc_i),
        .b_short_i (b_short_i),
        .b_kind_i  (b_kind_i),
        .fuse_o    (fuse_dec)
    );

    bsf_cond u_cond (
        .cond_i  (cond_q),
        .eq_i    (flag_eq_i),
        .lt_i    (flag_lt_i),
        .ltu_i   (flag_ltu_i),
        .taken_o (taken)
    );

    // Next state: decided from the pair sitting in decode.
    always_comb begin
        if (!pair_vld_i)    state_d = ST_IDLE;
        else if (fuse_dec)  state_d = ST_FUSED;
        else                state_d = ST_PASS;
    end

    // State register plus the fields the execute cycle still needs.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
            cond_q  <= 3'd0;
            bwr_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cond_q  <= a_cond_i;
            bwr_q   <= pair_vld_i && b_wr_i;
        end
    end

    // Outputs for the pair in execute.
    always_comb begin
        unique case (state_q)
            ST_IDLE: begin
                fuse_o    = 1'b0;
                b_wb_en_o = 1'b0;
            end
            ST_PASS: begin
                fuse_o    = 1'b0;
                b_wb_en_o = bwr_q;
            end
            ST_FUSED: begin
                fuse_o    = 1'b1;
                b_wb_en_o = bwr_q && !taken;
            end
            default: begin
                fuse_o    = 1'b0;
                b_wb_en_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/branch_skip_fuse_chk.sv
module branch_skip_fuse_chk
    import bsf_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic            pair_vld_i,
    input logic [2:0]      a_kind_i,
    input logic [2:0]      a_cond_i,
    input logic [XLEN-1:0] a_offs_i,
    input logic [2:0]      b_kind_i,
    input logic            b_wr_i,
    input logic            flag_eq_i,
    input logic            fuse_o,
    input logic            b_wb_en_o
);
    p_reset_quiet_r1: assert property (@(posedge clk_i)
        !rst_ni |=> !fuse_o && !b_wb_en_o);

    p_backward_never_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pair_vld_i && ($signed(a_offs_i) <= 0) |=> !fuse_o);

    p_non_alu_never_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pair_vld_i && (b_kind_i != K_ALU) |=> !fuse_o);

    p_non_branch_never_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pair_vld_i && (a_kind_i != K_BRANCH) |=> !fuse_o);

    p_eq_taken_squash_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fuse_o && flag_eq_i && ($past(a_cond_i) == C_EQ) |-> !b_wb_en_o);

    p_no_write_stays_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fuse_o && !$past(b_wr_i) |-> !b_wb_en_o);

    p_pass_through_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pair_vld_i && (a_kind_i != K_BRANCH) |=> b_wb_en_o == $past(b_wr_i));

    p_idle_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pair_vld_i |=> !fuse_o && !b_wb_en_o);

endmodule

bind branch_skip_fuse branch_skip_fuse_chk #(.XLEN(XLEN)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pair_vld_i (pair_vld_i),
    .a_kind_i   (a_kind_i),
    .a_cond_i   (a_cond_i),
    .a_offs_i   (a_offs_i),
    .b_kind_i   (b_kind_i),
    .b_wr_i     (b_wr_i),
    .flag_eq_i  (flag_eq_i),
    .fuse_o     (fuse_o),
    .b_wb_en_o  (b_wb_en_o)
);

// File: tb/test_branch_skip_fuse.sv
module test_branch_skip_fuse;
    localparam int XLEN = 32;

    logic            clk_i = 1'b0;
    logic            rst_ni = 1'b0;
    logic            pair_vld_i = 1'b0;
    logic [XLEN-1:0] a_pc_i = '0;
    logic            a_short_i = 1'b0;
    logic [2:0]      a_kind_i = '0;
    logic [2:0]      a_cond_i = '0;
    logic [XLEN-1:0] a_offs_i = '0;
    logic [XLEN-1:0] b_pc_i = '0;
    logic            b_short_i = 1'b0;
    logic [2:0]      b_kind_i = '0;
    logic            b_wr_i = 1'b0;
    logic            flag_eq_i = 1'b0;
    logic            flag_lt_i = 1'b0;
    logic            flag_ltu_i = 1'b0;
    logic            fuse_o, b_wb_en_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk_i = ~clk_i;

    branch_skip_fuse #(.XLEN(XLEN)) i_branch_skip_fuse (.*);

    task automatic chk(input string req, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", req, got, exp);
        end
    endtask

    function automatic logic ref_taken(input logic [2:0] c, input logic eq,
                                       input logic lt, input logic ltu);
        case (c)
            3'd0: return eq;
            3'd1: return !eq;
            3'd4: return lt;
            3'd5: return !lt;
            3'd6: return ltu;
            3'd7: return !ltu;
            default: return 1'b0;
        endcase
    endfunction

    // Present one pair, then drive execute flags and sample both outputs.
    task automatic run_pair(input logic [XLEN-1:0] apc, input logic ash,
                            input logic [2:0] ak, input logic [2:0] ac,
                            input logic [XLEN-1:0] offs, input logic [XLEN-1:0] bpc,
                            input logic bsh, input logic [2:0] bk, input logic bwr,
                            input logic [2:0] flags,
                            output logic f, output logic wb);
        @(negedge clk_i);
        pair_vld_i = 1'b1; a_pc_i = apc; a_short_i = ash; a_kind_i = ak;
        a_cond_i = ac; a_offs_i = offs; b_pc_i = bpc; b_short_i = bsh;
        b_kind_i = bk; b_wr_i = bwr;
        @(negedge clk_i);
        pair_vld_i = 1'b0;
        {flag_eq_i, flag_lt_i, flag_ltu_i} = flags;
        #1;
        f = fuse_o; wb = b_wb_en_o;
    endtask

    function automatic logic [XLEN-1:0] blen(input logic s);
        return s ? 32'd2 : 32'd4;
    endfunction

    task automatic t_reset;
        #1;
        chk("R1 fuse in reset", fuse_o, 1'b0);
        chk("R1 wb in reset", b_wb_en_o, 1'b0);
        @(negedge clk_i); rst_ni = 1'b1;
        #1;
        chk("R1 fuse after reset", fuse_o, 1'b0);
        chk("R1 wb after reset", b_wb_en_o, 1'b0);
    endtask

    task automatic t_lengths;
        for (int k = 0; k < 4; k++) begin
            logic sa = k[0], sb = k[1];
            logic f, wb;
            run_pair(32'h100, sa, 3'd3, 3'd0, blen(sa) + blen(sb), 32'h100 + blen(sa),
                     sb, 3'd0, 1'b1, 3'b000, f, wb);
            chk("R2 R3 fuse size combo", f, 1'b1);
            chk("R8 not taken keeps wb", wb, 1'b1);
            // same pair measured with the wrong lane B size
            run_pair(32'h100, sa, 3'd3, 3'd0, blen(sa) + blen(!sb), 32'h100 + blen(sa),
                     sb, 3'd0, 1'b1, 3'b100, f, wb);
            chk("R3 wrong lane B length", f, 1'b0);
            chk("R3 R10 wb unfused", wb, 1'b1);
        end
    endtask

    task automatic t_bad_offsets;
        logic [XLEN-1:0] offs [5] = '{32'd0, 32'hFFFF_FFF8, 32'd4, 32'd10, 32'd6};
        foreach (offs[i]) begin
            logic f, wb;
            run_pair(32'h200, 1'b0, 3'd3, 3'd0, offs[i], 32'h204, 1'b0, 3'd0, 1'b1,
                     3'b100, f, wb);
            chk("R4 bad offset no fuse", f, 1'b0);
            chk("R4 bad offset wb kept", wb, 1'b1);
        end
    endtask

    task automatic t_b_kinds;
        for (int k = 1; k < 8; k++) begin
            logic f, wb;
            run_pair(32'h300, 1'b1, 3'd3, 3'd0, 32'd6, 32'h302, 1'b0, 3'(k), 1'b1,
                     3'b100, f, wb);
            chk("R5 non-ALU lane B", f, 1'b0);
            chk("R5 R10 wb kept", wb, 1'b1);
        end
    endtask

    task automatic t_a_kinds;
        logic f, wb;
        for (int k = 0; k < 8; k++) begin
            if (k == 3) continue;
            run_pair(32'h400, 1'b0, 3'(k), 3'd0, 32'd8, 32'h404, 1'b0, 3'd0, 1'b1,
                     3'b100, f, wb);
            chk("R6 non-branch lane A", f, 1'b0);
        end
        for (int c = 2; c < 4; c++) begin
            run_pair(32'h400, 1'b0, 3'd3, 3'(c), 32'd8, 32'h404, 1'b0, 3'd0, 1'b1,
                     3'b111, f, wb);
            chk("R6 unknown condition", f, 1'b0);
            chk("R6 R10 wb kept", wb, 1'b1);
        end
    endtask

    task automatic t_not_adjacent;
        logic f, wb;
        // offset lands past B, but B is not directly after A
        run_pair(32'h500, 1'b0, 3'd3, 3'd0, 32'd12, 32'h508, 1'b0, 3'd0, 1'b1,
                 3'b100, f, wb);
        chk("R7 gap before lane B", f, 1'b0);
        chk("R7 wb kept", wb, 1'b1);
    endtask

    task automatic t_conditions;
        logic [2:0] codes [6] = '{3'd0, 3'd1, 3'd4, 3'd5, 3'd6, 3'd7};
        foreach (codes[i]) begin
            for (int fl = 0; fl < 8; fl++) begin
                logic f, wb, exp;
                run_pair(32'h600, 1'b1, 3'd3, codes[i], 32'd4, 32'h602, 1'b1, 3'd0,
                         1'b1, 3'(fl), f, wb);
                exp = !ref_taken(codes[i], fl[2], fl[1], fl[0]);
                chk("R9 fused", f, 1'b1);
                chk("R8 R9 predicated wb", wb, exp);
            end
        end
        for (int fl = 0; fl < 8; fl++) begin
            logic f, wb;
            run_pair(32'h600, 1'b1, 3'd3, 3'd1, 32'd4, 32'h602, 1'b1, 3'd0, 1'b0,
                     3'(fl), f, wb);
            chk("R8 non-writing lane B", wb, 1'b0);
        end
    endtask

    task automatic t_passthrough;
        for (int w = 0; w < 2; w++) begin
            for (int fl = 0; fl < 8; fl++) begin
                logic f, wb;
                run_pair(32'h700, 1'b0, 3'd0, 3'd0, 32'd8, 32'h704, 1'b0, 3'd0,
                         w[0], 3'(fl), f, wb);
                chk("R10 unfused fuse low", f, 1'b0);
                chk("R10 unfused wb", wb, w[0]);
            end
        end
    endtask

    task automatic t_idle;
        logic f, wb;
        run_pair(32'h800, 1'b0, 3'd3, 3'd0, 32'd8, 32'h804, 1'b0, 3'd0, 1'b1,
                 3'b000, f, wb);
        chk("R11 setup fused", f, 1'b1);
        @(negedge clk_i);
        {flag_eq_i, flag_lt_i, flag_ltu_i} = 3'b000;
        #1;
        chk("R11 idle fuse", fuse_o, 1'b0);
        chk("R11 idle wb", b_wb_en_o, 1'b0);
    endtask

    initial begin
        t_reset();
        t_lengths();
        t_bad_offsets();
        t_b_kinds();
        t_a_kinds();
        t_not_adjacent();
        t_conditions();
        t_passthrough();
        t_idle();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule